// File: doc/BRIEF.md
# Programmable Pulse Pattern Sequencer

The sequencer plays a stored program of instructions onto a parallel word of output flags. Every instruction carries an output pattern, a flow-control opcode, a data field, a short-pulse length and a delay count. The pattern is driven for the instruction's duration, and the duration is resolved to a single clock cycle. A host fills the internal program memory through a plain write port, starts the sequencer with a one-cycle pulse and watches four status flags. An abort input returns the sequencer to the waiting state.

Program flow covers plain advance, unconditional jump, counted loops, subroutine calls and returns, and stop. Loops and calls nest on two separate hardware stacks of configurable depth, 8 by default. The delay count is 52 bits wide, and any instruction shorter than five cycles is stretched to five. A short-pulse field can end the asserted part of the pattern after 1 to 7 cycles. The instruction still runs for its full duration. The next instruction is read ahead while the current one runs, so instructions follow each other with no gap.

Top module: `pulse_seq`

## Requirements
- R1: A program word written through the write port has this layout, from the most significant bit down: pattern (OUT_W bits), opcode (3 bits), data (DATA_W bits), short-pulse length (3 bits), delay (DELAY_W bits). The word is stored at wr_addr_i on a clock edge where wr_en_i is high.
- R2: An instruction whose delay is d lasts max(d,5) clock cycles, exact to one cycle.
- R3: The delay field is DELAY_W bits wide (52 by default), and all of its bits count, including those above bit 11.
- R4: When the short-pulse length s is nonzero, out_o shows the pattern for the first s cycles of the instruction and is zero for the rest. When s is 0, the pattern is shown for the whole instruction.
- R5: Consecutive instructions follow with no idle cycle between them, including after jumps, calls, returns and loop-backs.
- R6: The opcode codes are: 0 advance, 1 stop, 2 loop start, 3 loop end, 4 call, 5 return, 6 jump to data. Code 7 behaves as advance. Stop runs its own instruction and then halts with stopped_o high.
- R7: Loop start pushes its own address and the data field as a count. At loop end, if the top count is above 1, the count is decremented and execution goes to the loop start's address plus 1. Otherwise the entry is popped and execution falls through. A count of 0 behaves as 1.
- R8: Call pushes its address plus 1 and jumps to the data field. Return pops that address and continues from it.
- R9: Loops and calls each nest up to STK_DEPTH levels. A push onto a full stack halts the sequencer with error_o and stopped_o high once that instruction ends.
- R10: A return with an empty call stack, or a loop end with an empty loop stack, halts the sequencer with error_o and stopped_o high once that instruction ends.
- R11: Exactly one of waiting_o, running_o and stopped_o is high at all times. After reset and after an abort, waiting_o is high. out_o is zero whenever running_o is low.
- R12: start_i, given while the sequencer is not running, begins execution at address 0 on the next cycle. It clears error_o and both stacks. abort_i returns the sequencer to waiting on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Program memory write enable |
| wr_addr_i | input | ADDR_W | Program memory write address |
| wr_data_i | input | INSTR_W | Program word to write |
| start_i | input | 1 | Start the program at address 0 |
| abort_i | input | 1 | Return to the waiting state |
| out_o | output | OUT_W | Output flag pattern |
| waiting_o | output | 1 | Idle, ready to start |
| running_o | output | 1 | Program executing |
| stopped_o | output | 1 | Halted by stop or by a fault |
| error_o | output | 1 | The halt was caused by a stack fault |

## Verification
The timing core is swept over every delay from 0 to 9 combined with every short-pulse length from 0 to 7. This separates the stretch to five cycles from exact counting, and a truncated pulse from a full-length pattern. Two further delays, 1000 and 4099, show that the count is not clipped at the width of a narrow field. Flow is checked with hand-written programs: a single loop, a loop with a zero count, nested loops, nested calls followed by a jump, and abort. Each program has a distinct pattern on every address, so a wrong target, a skipped instruction or an inserted idle cycle appears as a wrong word in the cycle-by-cycle trace. Fault programs fill each stack one level beyond its depth, or pop from an empty stack, and expect the halt to land after exactly the right instruction.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  typedef enum logic [2:0] {
    OP_NEXT   = 3'd0,
    OP_STOP   = 3'd1,
    OP_LOOP   = 3'd2,
    OP_ENDL   = 3'd3,
    OP_CALL   = 3'd4,
    OP_RET    = 3'd5,
    OP_JUMP   = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_HALT = 2'd2
  } state_e;

  localparam int unsigned MIN_CYC = 5;
  localparam int unsigned SP_W    = 3;
  localparam int unsigned OP_W    = 3;
endpackage

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         upd_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [W-1:0]  ent_q [DEPTH];
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] top_idx;

  assign top_idx = cnt_q - 1'b1;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == PW'(DEPTH));
  assign top_o   = ent_q[top_idx[IW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o)      ent_q[cnt_q[IW-1:0]]   <= data_i;
    else if (upd_i && !empty_o) ent_q[top_idx[IW-1:0]] <= data_i;
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer
  import pulse_seq_pkg::*;
#(
  parameter int unsigned W = 52
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [W-1:0]    dly_i,
  input  logic [SP_W-1:0] sp_i,
  output logic            act_o,
  output logic            last_o
);
  logic [W-1:0]    rem_q;
  logic [SP_W-1:0] el_q, sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      el_q  <= '0;
      sp_q  <= '0;
    end else if (ld_i) begin
      // duration below the minimum is stretched
      rem_q <= (dly_i < W'(MIN_CYC)) ? W'(MIN_CYC - 1) : dly_i - 1'b1;
      el_q  <= '0;
      sp_q  <= sp_i;
    end else begin
      if (rem_q != '0) rem_q <= rem_q - 1'b1;
      if (el_q != '1)  el_q  <= el_q + 1'b1;
    end
  end

  assign last_o = (rem_q == '0);
  assign act_o  = (sp_q == '0) || (el_q < sp_q);
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
  import pulse_seq_pkg::*;
#(
  parameter int unsigned OUT_W     = 24,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned DELAY_W   = 52,
  parameter int unsigned STK_DEPTH = 8,
  localparam int unsigned INSTR_W  = OUT_W + OP_W + DATA_W + SP_W + DELAY_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [INSTR_W-1:0] wr_data_i,
  input  logic               start_i,
  input  logic               abort_i,
  output logic [OUT_W-1:0]   out_o,
  output logic               waiting_o,
  output logic               running_o,
  output logic               stopped_o,
  output logic               error_o
);
  localparam int unsigned SP_LSB  = DELAY_W;
  localparam int unsigned CUR_LSB = SP_LSB + SP_W;
  localparam int unsigned CUR_W   = INSTR_W - CUR_LSB;
  localparam int unsigned LP_W    = ADDR_W + DATA_W;
  localparam int unsigned DEPTH   = 1 << ADDR_W;

  logic [INSTR_W-1:0] mem_q [DEPTH];
  logic [INSTR_W-1:0] pre_q;
  logic [CUR_W-1:0]   cur_q;
  logic [ADDR_W-1:0]  pc_q, nxt_pc, rd_addr;
  state_e             state_q;
  logic               err_q;

  logic [OUT_W-1:0]   pat;
  op_e                op;
  logic [DATA_W-1:0]  dat;
  assign {pat, op, dat} = cur_q;

  logic act, last, run_end, start_go, instr_ld, halt, fault;
  logic lp_push, lp_pop, lp_upd, sb_push, sb_pop, stk_clr;
  logic [LP_W-1:0]   lp_top, lp_wdata;
  logic [ADDR_W-1:0] sb_top;
  logic lp_empty, lp_full, sb_empty, sb_full;
  logic [ADDR_W-1:0] lp_addr;
  logic [DATA_W-1:0] lp_cnt;
  assign {lp_addr, lp_cnt} = lp_top;

  // program memory with continuous read-ahead of the next address
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    pre_q <= mem_q[rd_addr];
  end

  assign run_end  = (state_q == S_RUN) && last;
  assign start_go = start_i && !abort_i && (state_q != S_RUN);
  assign stk_clr  = start_go || abort_i;

  always_comb begin
    nxt_pc   = pc_q + 1'b1;
    halt     = 1'b0;
    fault    = 1'b0;
    lp_push  = 1'b0;
    lp_pop   = 1'b0;
    lp_upd   = 1'b0;
    sb_push  = 1'b0;
    sb_pop   = 1'b0;
    lp_wdata = {pc_q, dat};
    unique case (op)
      OP_STOP: halt = 1'b1;
      OP_LOOP: begin
        if (lp_full) fault = 1'b1;
        else         lp_push = 1'b1;
      end
      OP_ENDL: begin
        if (lp_empty) fault = 1'b1;
        else if (lp_cnt <= DATA_W'(1)) lp_pop = 1'b1;
        else begin
          lp_upd   = 1'b1;
          lp_wdata = {lp_addr, lp_cnt - 1'b1};
          nxt_pc   = lp_addr + 1'b1;
        end
      end
      OP_CALL: begin
        if (sb_full) fault = 1'b1;
        else begin
          sb_push = 1'b1;
          nxt_pc  = dat[ADDR_W-1:0];
        end
      end
      OP_RET: begin
        if (sb_empty) fault = 1'b1;
        else begin
          sb_pop = 1'b1;
          nxt_pc = sb_top;
        end
      end
      OP_JUMP: nxt_pc = dat[ADDR_W-1:0];
      default: ;
    endcase
  end

  assign rd_addr  = (state_q == S_RUN) ? nxt_pc : '0;
  assign instr_ld = start_go || (run_end && !halt && !fault);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
      pc_q    <= '0;
      cur_q   <= '0;
    end else if (abort_i) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
    end else if (start_go) begin
      state_q <= S_RUN;
      err_q   <= 1'b0;
      pc_q    <= '0;
      cur_q   <= pre_q[INSTR_W-1:CUR_LSB];
    end else if (run_end) begin
      if (fault || halt) begin
        state_q <= S_HALT;
        err_q   <= fault;
      end else begin
        pc_q  <= nxt_pc;
        cur_q <= pre_q[INSTR_W-1:CUR_LSB];
      end
    end
  end

  seq_timer #(.W(DELAY_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (instr_ld),
    .dly_i  (pre_q[DELAY_W-1:0]),
    .sp_i   (pre_q[SP_LSB +: SP_W]),
    .act_o  (act),
    .last_o (last)
  );

  seq_stack #(.W(LP_W), .DEPTH(STK_DEPTH)) loop_stk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (stk_clr),
    .push_i  (run_end && lp_push),
    .pop_i   (run_end && lp_pop),
    .upd_i   (run_end && lp_upd),
    .data_i  (lp_wdata),
    .top_o   (lp_top),
    .empty_o (lp_empty),
    .full_o  (lp_full)
  );

  seq_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) call_stk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (stk_clr),
    .push_i  (run_end && sb_push),
    .pop_i   (run_end && sb_pop),
    .upd_i   (1'b0),
    .data_i  (pc_q + 1'b1),
    .top_o   (sb_top),
    .empty_o (sb_empty),
    .full_o  (sb_full)
  );

  assign running_o = (state_q == S_RUN);
  assign waiting_o = (state_q == S_IDLE);
  assign stopped_o = (state_q == S_HALT);
  assign error_o   = err_q;
  assign out_o     = (running_o && act) ? pat : '0;
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk #(
  parameter int unsigned OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             abort_i,
  input logic [OUT_W-1:0] out_o,
  input logic             waiting_o,
  input logic             running_o,
  input logic             stopped_o,
  input logic             error_o,
  input logic             ld_i
);
  logic [2:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= 3'd7;
    else if (ld_i)       gap_q <= '0;
    else if (gap_q != 7) gap_q <= gap_q + 1'b1;
  end

  // R11
  status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({waiting_o, running_o, stopped_o}) == 1);

  // R11
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> (out_o == '0));

  // R10
  err_means_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> stopped_o);

  // R9
  err_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> $past(running_o));

  // R2
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && running_o) |-> (gap_q >= 3'd4));

  // R12
  start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i && !running_o) |=> running_o);

  // R12
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> waiting_o);
endmodule

bind pulse_seq pulse_seq_chk #(.OUT_W(OUT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .abort_i   (abort_i),
  .out_o     (out_o),
  .waiting_o (waiting_o),
  .running_o (running_o),
  .stopped_o (stopped_o),
  .error_o   (error_o),
  .ld_i      (instr_ld)
);

// File: tb/pulse_seq_tb_top.sv
module pulse_seq_tb_top;
  localparam int OUT_W = 24, ADDR_W = 8, DATA_W = 12, DELAY_W = 52, DEPTH = 8;
  localparam int INSTR_W = OUT_W + 3 + DATA_W + 3 + DELAY_W;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, start = 0, abort = 0;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [INSTR_W-1:0] wr_data = '0;
  logic [OUT_W-1:0]   out;
  logic waiting, running, stopped, error;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulse_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .abort_i(abort), .out_o(out),
    .waiting_o(waiting), .running_o(running), .stopped_o(stopped), .error_o(error)
  );

  function automatic logic [INSTR_W-1:0] mk(input logic [23:0] pat, input logic [2:0] op,
      input logic [11:0] dat, input logic [2:0] sp, input logic [51:0] dly);
    return {pat, op, dat, sp, dly};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [INSTR_W-1:0] w);
    @(negedge clk);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic go();
    @(negedge clk); @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // one instruction: expected output per cycle, then advance
  task automatic seg(input logic [23:0] pat, input int sp, input int dly, input string req);
    int dur = (dly < 5) ? 5 : dly;
    for (int i = 0; i < dur; i++) begin
      logic [23:0] e = (sp == 0 || i < sp) ? pat : 24'h0;
      chk(out === e && running === 1'b1, req, {39'h0, running, out}, {39'h0, 1'b1, e});
      @(negedge clk);
    end
  endtask

  task automatic halted(input bit e, input string req);
    chk(stopped === 1 && running === 0 && waiting === 0 && error === e && out === '0,
        req, {stopped, running, waiting, error, out}, {1'b1, 1'b0, 1'b0, e, 24'h0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(waiting === 1 && running === 0 && stopped === 0 && error === 0 && out === '0,
        "R11 reset", {waiting, running, stopped, error}, 4'b1000);

    // R2 R4 R1 sweep of delay and short-pulse length
    for (int d = 0; d < 10; d++) begin
      for (int s = 0; s < 8; s++) begin
        logic [23:0] p = 24'hA00000 | 24'(d << 4) | 24'(s);
        wr(0, mk(p, 3'd0, 12'd0, 3'(s), 52'(d)));
        wr(1, mk(24'h000005, 3'd1, 12'd0, 3'd0, 52'd5));
        go();
        seg(p, s, d, "R2_R4 sweep");
        seg(24'h000005, 0, 5, "R5 stop instr");
        halted(0, "R6 stop");
      end
    end

    // R3 long delays, bits above the low 12 count
    wr(0, mk(24'h111111, 3'd0, 12'd0, 3'd0, 52'd1000));
    wr(1, mk(24'h222222, 3'd0, 12'd0, 3'd2, 52'd4099));
    wr(2, mk(24'h333333, 3'd1, 12'd0, 3'd0, 52'd6));
    go();
    seg(24'h111111, 0, 1000, "R3 d1000");
    seg(24'h222222, 2, 4099, "R3 d4099");
    seg(24'h333333, 0, 6, "R3 tail");
    halted(0, "R3 stop");

    // R7 single loop, count 3
    wr(0, mk(24'h00000A, 3'd2, 12'd3, 3'd0, 52'd5));
    wr(1, mk(24'h00000B, 3'd0, 12'd0, 3'd0, 52'd6));
    wr(2, mk(24'h00000C, 3'd3, 12'd0, 3'd0, 52'd5));
    wr(3, mk(24'h00000D, 3'd1, 12'd0, 3'd0, 52'd5));
    go();
    seg(24'h00000A, 0, 5, "R7 loop");
    for (int k = 0; k < 3; k++) begin
      seg(24'h00000B, 0, 6, "R7 body");
      seg(24'h00000C, 0, 5, "R7 end");
    end
    seg(24'h00000D, 0, 5, "R7 exit");
    halted(0, "R7 stop");

    // R7 zero count runs once
    wr(0, mk(24'h00000A, 3'd2, 12'd0, 3'd0, 52'd5));
    go();
    seg(24'h00000A, 0, 5, "R7 zero");
    seg(24'h00000B, 0, 6, "R7 zero body");
    seg(24'h00000C, 0, 5, "R7 zero end");
    seg(24'h00000D, 0, 5, "R7 zero exit");
    halted(0, "R7 zero stop");

    // R7 R5 nested loops 2 x 3
    wr(0, mk(24'h0000A1, 3'd2, 12'd2, 3'd0, 52'd5));
    wr(1, mk(24'h0000B1, 3'd2, 12'd3, 3'd0, 52'd5));
    wr(2, mk(24'h0000C1, 3'd3, 12'd0, 3'd0, 52'd5));
    wr(3, mk(24'h0000D1, 3'd3, 12'd0, 3'd0, 52'd5));
    wr(4, mk(24'h0000E1, 3'd1, 12'd0, 3'd0, 52'd5));
    go();
    seg(24'h0000A1, 0, 5, "R7 nest");
    for (int o = 0; o < 2; o++) begin
      seg(24'h0000B1, 0, 5, "R7 inner start");
      for (int i = 0; i < 3; i++) seg(24'h0000C1, 0, 5, "R7 inner end");
      seg(24'h0000D1, 0, 5, "R7 outer end");
    end
    seg(24'h0000E1, 0, 5, "R5 nest exit");
    halted(0, "R7 nest stop");

    // R8 R6 nested calls then jump
    wr(0,  mk(24'h0000F0, 3'd4, 12'd8,  3'd0, 52'd5));
    wr(1,  mk(24'h0000F1, 3'd6, 12'd4,  3'd0, 52'd5));
    wr(4,  mk(24'h0000F4, 3'd1, 12'd0,  3'd0, 52'd5));
    wr(8,  mk(24'h0000F8, 3'd4, 12'd12, 3'd0, 52'd5));
    wr(9,  mk(24'h0000F9, 3'd5, 12'd0,  3'd0, 52'd5));
    wr(12, mk(24'h0000FC, 3'd5, 12'd0,  3'd0, 52'd7));
    go();
    seg(24'h0000F0, 0, 5, "R8 call");
    seg(24'h0000F8, 0, 5, "R8 call2");
    seg(24'h0000FC, 0, 7, "R8 ret2");
    seg(24'h0000F9, 0, 5, "R8 ret1");
    seg(24'h0000F1, 0, 5, "R6 jump");
    seg(24'h0000F4, 0, 5, "R6 target");
    halted(0, "R8 stop");

    // R10 return on empty stack
    wr(0, mk(24'h000011, 3'd5, 12'd0, 3'd0, 52'd5));
    go();
    seg(24'h000011, 0, 5, "R10 ret empty");
    halted(1, "R10 ret fault");

    // R10 loop end on empty stack, R12 restart clears error
    wr(0, mk(24'h000012, 3'd3, 12'd0, 3'd0, 52'd5));
    go();
    chk(error === 0, "R12 err cleared", {63'h0, error}, 64'h0);
    seg(24'h000012, 0, 5, "R10 endl empty");
    halted(1, "R10 endl fault");

    // R9 loop stack overflow at depth+1
    for (int a = 0; a <= DEPTH; a++) wr(a, mk(24'(a + 1), 3'd2, 12'd1, 3'd0, 52'd5));
    go();
    for (int a = 0; a <= DEPTH; a++) seg(24'(a + 1), 0, 5, "R9 loop push");
    halted(1, "R9 loop overflow");

    // R9 call stack overflow
    wr(0, mk(24'h000022, 3'd4, 12'd0, 3'd0, 52'd5));
    go();
    for (int a = 0; a <= DEPTH; a++) seg(24'h000022, 0, 5, "R9 call push");
    halted(1, "R9 call overflow");

    // R12 abort mid-instruction
    wr(0, mk(24'h000033, 3'd0, 12'd0, 3'd0, 52'd100));
    go();
    seg(24'h000033, 0, 5, "R12 pre-abort");
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(waiting === 1 && running === 0 && stopped === 0 && error === 0 && out === '0,
        "R12 abort", {waiting, running, stopped, error, out}, {4'b1000, 24'h0});
    repeat (3) @(negedge clk);
    chk(waiting === 1 && out === '0, "R11 stays waiting", {waiting, out}, {1'b1, 24'h0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule